// File: doc/BRIEF.md
# Signed Weight Row Matrix

This block forms the row results of one tile during its read phase. Eight input lanes arrive as unsigned values wider than four bits. Each lane is clamped to a 4-bit level of at most 15, and a per-lane flag records whether the raw value was clipped. An 8x8 array of 4-bit weight magnitudes, each with its own sign bit, is applied to the clamped levels. For every row the block produces the signed sum over all lanes of level times magnitude, with the weight's sign applied. It also produces an unsigned 4-bit row level: the positive part of that sum, divided by eight with round-up, then saturated to 15.

The block also selects the tile's eight-lane drive vector. When the lock status is set, each lane passes its clamped input straight through. Otherwise the lanes carry the eight row levels. No lane or row can be masked.

A one-cycle start pulse begins a computation, which evaluates one row per clock. A done strobe marks the cycle in which every result is valid. Results then hold until the next start. The weights are kept outside the block. The inputs, weights and lock status must stay stable from start until done.

Top module: `tile_row_mac`

## Requirements
- R1: Each input lane i (bits [8i+7:8i] of `in_raw`) is clamped to min(value, 15) before use. The clamped level appears on drive lane i (bits [4i+3:4i] of `drive`) when the tile is locked.
- R2: `clip` bit i is 1 after done exactly when raw input lane i exceeded 15.
- R3: Row r of `row_raw` (bits [12r+11:12r], two's complement) equals the sum over lanes i of clamped level i times magnitude `w_mag[(8r+i)*4 +: 4]`. A term is negated when `w_neg[8r+i]` is 1.
- R4: Row level r (bits [4r+3:4r] of `row_lvl`) is 0 when the row sum is zero or negative. Otherwise it is (sum + 7) / 8 with integer division, saturated to 15.
- R5: When `locked` is 1, every drive lane equals the clamped input of the same lane.
- R6: When `locked` is 0, drive lane i equals row level i.
- R7: `done` is high for exactly one cycle, ROWS (8) cycles after the clock edge that accepts `start`. `busy` is high from that edge until done.
- R8: A `start` pulse while `busy` is high is ignored. The run in progress keeps its timing, and no second done follows.
- R9: After reset, `busy` and `done` are low and all result outputs are zero.
- R10: When no run is in progress, all result outputs hold their values, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compute; accepted only when idle |
| locked | input | 1 | Tile lock status; 1 selects input passthrough on the drive vector |
| in_raw | input | 64 | Eight unsigned 8-bit input lanes |
| w_mag | input | 256 | 64 weight magnitudes, 4 bits each, row-major |
| w_neg | input | 64 | Weight sign bits, 1 = negative, row-major |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe; all results valid |
| row_raw | output | 96 | Eight signed 12-bit row sums |
| row_lvl | output | 32 | Eight 4-bit row levels |
| drive | output | 32 | Eight 4-bit drive lanes |
| clip | output | 8 | Per-lane input clip flags |

## Verification
The checker assumes that the inputs, weights and lock status do not change between the accepted start and the done strobe. Its passthrough check compares the drive vector, at done, against the inputs present in that cycle. The bench therefore changes stimulus only while the block is idle. In the tests that ignore a start or hold the results, only `start`, or only idle-time inputs, move. Every product is bounded by 15x15, so the sums stay within the 12-bit signed range, and the stimulus includes the extreme values of both signs.

// File: rtl/tile_row_pkg.sv
package tile_row_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/lane_clamp.sv
module lane_clamp #(
    parameter int IN_W  = 8,
    parameter int LVL_W = 4
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             clip_o
);
    localparam logic [IN_W-1:0] MAXV = IN_W'((1 << LVL_W) - 1);

    always_comb begin
        clip_o = (raw_i > MAXV);
        lvl_o  = clip_o ? MAXV[LVL_W-1:0] : raw_i[LVL_W-1:0];
    end
endmodule

// File: rtl/row_dot.sv
module row_dot #(
    parameter int LANES = 8,
    parameter int LVL_W = 4,
    parameter int W_W   = 4,
    parameter int SUM_W = 12
) (
    input  logic [LANES*LVL_W-1:0]  lvl_i,
    input  logic [LANES*W_W-1:0]    mag_i,
    input  logic [LANES-1:0]        neg_i,
    output logic signed [SUM_W-1:0] sum_o
);
    localparam int PROD_W = LVL_W + W_W;

    logic [PROD_W-1:0]        prod;
    logic signed [SUM_W-1:0]  term;
    logic signed [SUM_W-1:0]  acc;

    always_comb begin
        acc  = '0;
        prod = '0;
        term = '0;
        for (int i = 0; i < LANES; i++) begin
            prod = PROD_W'(lvl_i[i*LVL_W +: LVL_W]) * PROD_W'(mag_i[i*W_W +: W_W]);
            term = $signed({{(SUM_W-PROD_W){1'b0}}, prod});
            acc  = neg_i[i] ? (acc - term) : (acc + term);
        end
        sum_o = acc;
    end
endmodule

// File: rtl/row_level.sv
module row_level #(
    parameter int SUM_W   = 12,
    parameter int LVL_W   = 4,
    parameter int DIV_LOG = 3
) (
    input  logic signed [SUM_W-1:0] sum_i,
    output logic [LVL_W-1:0]        lvl_o
);
    localparam logic [SUM_W-1:0] BIAS = SUM_W'((1 << DIV_LOG) - 1);
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << LVL_W) - 1);

    logic [SUM_W-1:0] biased;
    logic [SUM_W-1:0] quot;

    always_comb begin
        biased = $unsigned(sum_i) + BIAS;
        quot   = biased >> DIV_LOG;
        if (sum_i <= 0)
            lvl_o = '0;
        else if (quot > MAXV)
            lvl_o = MAXV[LVL_W-1:0];
        else
            lvl_o = quot[LVL_W-1:0];
    end
endmodule

// File: rtl/tile_row_mac.sv
module tile_row_mac
    import tile_row_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ROWS  = 8,
    parameter int IN_W  = 8,
    parameter int W_W   = 4,
    parameter int LVL_W = 4,
    parameter int SUM_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    locked,
    input  logic [LANES*IN_W-1:0]   in_raw,
    input  logic [ROWS*LANES*W_W-1:0] w_mag,
    input  logic [ROWS*LANES-1:0]   w_neg,
    output logic                    busy,
    output logic                    done,
    output logic [ROWS*SUM_W-1:0]   row_raw,
    output logic [ROWS*LVL_W-1:0]   row_lvl,
    output logic [LANES*LVL_W-1:0]  drive,
    output logic [LANES-1:0]        clip
);
    localparam int IDX_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int ROW_MAG = LANES * W_W;

    typedef struct packed {
        phase_e                   phase;
        logic                     done;
        logic [IDX_W-1:0]         idx;
        logic [ROWS*SUM_W-1:0]    raw;
        logic [ROWS*LVL_W-1:0]    lvl;
        logic [LANES*LVL_W-1:0]   drv;
        logic [LANES-1:0]         clip;
    } state_t;

    state_t st_d, st_q;

    // lane clamping, one instance per lane
    logic [LANES*LVL_W-1:0] in_lvl;
    logic [LANES-1:0]       in_clip;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_clamp #(.IN_W(IN_W), .LVL_W(LVL_W)) u_clamp (
            .raw_i  (in_raw[g*IN_W +: IN_W]),
            .lvl_o  (in_lvl[g*LVL_W +: LVL_W]),
            .clip_o (in_clip[g])
        );
    end

    // the row selected by the running index
    logic [ROW_MAG-1:0]      cur_mag;
    logic [LANES-1:0]        cur_neg;
    logic signed [SUM_W-1:0] cur_sum;
    logic [LVL_W-1:0]        cur_lvl;

    always_comb begin
        cur_mag = w_mag[st_q.idx*ROW_MAG +: ROW_MAG];
        cur_neg = w_neg[st_q.idx*LANES +: LANES];
    end

    row_dot #(.LANES(LANES), .LVL_W(LVL_W), .W_W(W_W), .SUM_W(SUM_W)) u_dot (
        .lvl_i (in_lvl),
        .mag_i (cur_mag),
        .neg_i (cur_neg),
        .sum_o (cur_sum)
    );

    row_level #(.SUM_W(SUM_W), .LVL_W(LVL_W), .DIV_LOG(3)) u_level (
        .sum_i (cur_sum),
        .lvl_o (cur_lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.idx   = '0;
                end
            end
            PH_RUN: begin
                st_d.raw[st_q.idx*SUM_W +: SUM_W] = cur_sum;
                st_d.lvl[st_q.idx*LVL_W +: LVL_W] = cur_lvl;
                if (st_q.idx == IDX_W'(ROWS - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.clip  = in_clip;
                    st_d.drv   = locked ? in_lvl : st_d.lvl[LANES*LVL_W-1:0];
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign done    = st_q.done;
    assign row_raw = st_q.raw;
    assign row_lvl = st_q.lvl;
    assign drive   = st_q.drv;
    assign clip    = st_q.clip;
endmodule

// File: rtl/tile_row_mac_chk.sv
module tile_row_mac_chk #(
    parameter int LANES = 8,
    parameter int ROWS  = 8,
    parameter int IN_W  = 8,
    parameter int W_W   = 4,
    parameter int LVL_W = 4,
    parameter int SUM_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      locked,
    input logic [LANES*IN_W-1:0]     in_raw,
    input logic [ROWS*LANES*W_W-1:0] w_mag,
    input logic [ROWS*LANES-1:0]     w_neg,
    input logic                      busy,
    input logic                      done,
    input logic [ROWS*SUM_W-1:0]     row_raw,
    input logic [ROWS*LVL_W-1:0]     row_lvl,
    input logic [LANES*LVL_W-1:0]    drive,
    input logic [LANES-1:0]          clip
);
    localparam int CNT_W = $clog2(ROWS + 1) + 1;
    localparam int LMAX  = (1 << LVL_W) - 1;

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else          run_cnt <= '0;
    end

    function automatic bit pass_ok(input logic [LANES*IN_W-1:0] raw,
                                   input logic [LANES*LVL_W-1:0] drv);
        bit ok = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (int'(raw[i*IN_W +: IN_W]) > LMAX) begin
                if (int'(drv[i*LVL_W +: LVL_W]) != LMAX) ok = 1'b0;
            end else if (int'(drv[i*LVL_W +: LVL_W]) != int'(raw[i*IN_W +: IN_W])) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

    function automatic bit level_ok(input logic [ROWS*SUM_W-1:0] sums,
                                    input logic [ROWS*LVL_W-1:0] lvls);
        bit ok = 1'b1;
        for (int r = 0; r < ROWS; r++) begin
            int s;
            int l;
            s = int'($signed(sums[r*SUM_W +: SUM_W]));
            l = int'(lvls[r*LVL_W +: LVL_W]);
            if (s <= 0) begin
                if (l != 0) ok = 1'b0;
            end else begin
                if (l == 0) ok = 1'b0;
                else if ((l - 1) * 8 >= s) ok = 1'b0;
                else if (l * 8 < s && l != LMAX) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    // R7: done lasts one cycle and comes ROWS cycles into the run
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CNT_W'(ROWS)) && !busy);
    // R8: no start can make a run longer than ROWS cycles
    a_r8_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(ROWS)));
    // R4: row levels agree with the row sums
    a_r4_level_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> level_ok(row_raw, row_lvl));
    // R5: passthrough when locked
    a_r5_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (done && locked) |-> pass_ok(in_raw, drive));
    // R6: row levels on the drive lanes when unlocked
    a_r6_row_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !locked) |-> (drive == row_lvl[LANES*LVL_W-1:0]));
    // R10: results hold while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> ($stable(row_raw) && $stable(row_lvl)
                              && $stable(drive) && $stable(clip)));
endmodule

bind tile_row_mac tile_row_mac_chk #(
    .LANES(LANES), .ROWS(ROWS), .IN_W(IN_W),
    .W_W(W_W), .LVL_W(LVL_W), .SUM_W(SUM_W)
) u_chk (.*);

// File: tb/tile_row_mac_tb.sv
`timescale 1ns/1ps
module tile_row_mac_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         locked = 1'b0;
    logic [63:0]  in_raw;
    logic [255:0] w_mag;
    logic [63:0]  w_neg;
    logic         busy, done;
    logic [95:0]  row_raw;
    logic [31:0]  row_lvl;
    logic [31:0]  drive;
    logic [7:0]   clip;

    int in_a [8];
    int wm   [8][8];
    bit wn   [8][8];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            in_raw[i*8 +: 8] = 8'(in_a[i]);
            for (int r = 0; r < 8; r++) begin
                w_mag[(r*8+i)*4 +: 4] = 4'(wm[r][i]);
                w_neg[r*8+i]          = wn[r][i];
            end
        end
    end

    tile_row_mac u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .locked(locked),
        .in_raw(in_raw), .w_mag(w_mag), .w_neg(w_neg),
        .busy(busy), .done(done), .row_raw(row_raw), .row_lvl(row_lvl),
        .drive(drive), .clip(clip)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp15(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    function automatic int exp_sum(input int r);
        int s = 0;
        for (int i = 0; i < 8; i++)
            s += (wn[r][i] ? -1 : 1) * clamp15(in_a[i]) * wm[r][i];
        return s;
    endfunction

    function automatic int exp_lvl(input int s);
        int q;
        if (s <= 0) return 0;
        q = (s + 7) / 8;
        return (q > 15) ? 15 : q;
    endfunction

    // start a run and return the number of cycles until done
    task automatic run(output int lat);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_results(input string tag);
        for (int r = 0; r < 8; r++) begin
            int a = int'($signed(row_raw[r*12 +: 12]));
            check(a == exp_sum(r), "R3", {tag, " row sum"}, a, exp_sum(r));
            check(int'(row_lvl[r*4 +: 4]) == exp_lvl(exp_sum(r)), "R4",
                  {tag, " row level"}, int'(row_lvl[r*4 +: 4]), exp_lvl(exp_sum(r)));
        end
        for (int i = 0; i < 8; i++) begin
            int e = locked ? clamp15(in_a[i]) : exp_lvl(exp_sum(i));
            check(int'(drive[i*4 +: 4]) == e, locked ? "R5" : "R6",
                  {tag, " drive lane"}, int'(drive[i*4 +: 4]), e);
            check(clip[i] == (in_a[i] > 15), "R2", {tag, " clip flag"},
                  int'(clip[i]), int'(in_a[i] > 15));
        end
    endtask

    task automatic run_and_check(input string tag);
        int lat;
        run(lat);
        check(lat == 8, "R7", {tag, " done latency"}, lat, 8);
        check_results(tag);
        @(negedge clk);
        check(done == 1'b0, "R7", {tag, " done one cycle"}, int'(done), 0);
    endtask

    task automatic t_reset;
        check(busy == 1'b0 && done == 1'b0, "R9", "reset control", int'({busy, done}), 0);
        check(row_raw == '0 && row_lvl == '0, "R9", "reset rows", int'(row_lvl), 0);
        check(drive == '0 && clip == '0, "R9", "reset drive", int'(drive), 0);
    endtask

    task automatic t_positive;
        for (int i = 0; i < 8; i++) begin
            in_a[i] = i + 3;
            for (int r = 0; r < 8; r++) begin wm[r][i] = (r + i) % 16; wn[r][i] = 0; end
        end
        locked = 1'b0;
        run_and_check("positive");
    endtask

    task automatic t_signs;
        for (int i = 0; i < 8; i++) begin
            in_a[i] = 15 - i;
            for (int r = 0; r < 8; r++) begin
                wm[r][i] = (3 * r + 5 * i) % 16;
                wn[r][i] = ((r + i) % 3 == 0) || (r >= 6);
            end
        end
        locked = 1'b0;
        run_and_check("mixed signs");
    endtask

    task automatic t_clamp_unlocked;
        for (int i = 0; i < 8; i++) begin
            in_a[i] = (i % 2) ? 200 + i : 16 + i;
            for (int r = 0; r < 8; r++) begin wm[r][i] = 1; wn[r][i] = (r == 1); end
        end
        in_a[7] = 15;
        locked = 1'b0;
        run_and_check("clamp R1");
    endtask

    task automatic t_locked;
        for (int i = 0; i < 8; i++) in_a[i] = (i == 2) ? 255 : i * 2;
        locked = 1'b1;
        run_and_check("locked R1");
        locked = 1'b0;
    endtask

    task automatic t_round;
        // lane 0 = 1, lane 1 = 15; rows built to hit rounding edges
        for (int i = 0; i < 8; i++) begin
            in_a[i] = (i == 0) ? 1 : (i == 1) ? 15 : 0;
            for (int r = 0; r < 8; r++) begin wm[r][i] = 0; wn[r][i] = 0; end
        end
        wm[0][0] = 1;                          // 1 -> 1
        wm[1][0] = 8;                          // 8 -> 1
        wm[2][0] = 9;                          // 9 -> 2
        wm[3][1] = 8;                          // 120 -> 15
        wm[4][1] = 9;                          // 135 -> 15 saturated
        wm[5][0] = 7; wn[5][0] = 1;            // -7 -> 0
        wm[6][1] = 1; wm[6][0] = 15; wn[6][0] = 1; // 0 -> 0
        wm[7][1] = 7; wm[7][0] = 1;            // 106 -> 14
        locked = 1'b0;
        run_and_check("rounding R4");
    endtask

    task automatic t_extreme;
        for (int i = 0; i < 8; i++) begin
            in_a[i] = 255;
            for (int r = 0; r < 8; r++) begin wm[r][i] = 15; wn[r][i] = r[0]; end
        end
        locked = 1'b0;
        run_and_check("extreme R3");
    endtask

    task automatic t_restart;
        int lat;
        int extra = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1;                           // R8: ignored, block is busy
        @(negedge clk); start = 1'b0;
        lat = 3;
        while (!done && lat < 50) begin @(negedge clk); lat++; end
        check(lat == 8, "R8", "latency with start while busy", lat, 8);
        repeat (12) begin @(negedge clk); if (done || busy) extra++; end
        check(extra == 0, "R8", "no second run", extra, 0);
    endtask

    task automatic t_hold;
        logic [95:0] raw_s = row_raw;
        logic [31:0] drv_s = drive;
        logic [7:0]  clp_s = clip;
        for (int i = 0; i < 8; i++) begin
            in_a[i] = 7;
            for (int r = 0; r < 8; r++) wm[r][i] = 2;
        end
        locked = 1'b1;
        repeat (6) @(negedge clk);
        check(row_raw == raw_s, "R10", "row sums held", int'(row_raw[11:0]), int'(raw_s[11:0]));
        check(drive == drv_s, "R10", "drive held", int'(drive), int'(drv_s));
        check(clip == clp_s, "R10", "clip held", int'(clip), int'(clp_s));
        locked = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            in_a[i] = 0;
            for (int r = 0; r < 8; r++) begin wm[r][i] = 0; wn[r][i] = 0; end
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_positive();
        t_signs();
        t_clamp_unlocked();
        t_locked();
        t_round();
        t_extreme();
        t_restart();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule